// File: doc/BRIEF.md
# Three-Port Latchable Bus Router

This block moves 9-bit words among three ports, A, B and C. Each port has its own input bus, its own output bus and a drive flag that says when the port should actually drive. A word can be sent from any port to one or both of the other ports. Port A and port B can also present their own earlier captured word again, which is useful for self-checks. Bit 8 is treated as a parity bit. On the paths that leave port C, it can be inverted on purpose to inject parity errors.

Six one-way paths join the ports: A to B, B to A, A to C, C to A, B to C and C to B. Each path has its own latch enable. While the enable is low the path is transparent, and the destination sees the source in the same cycle. While the enable is high the path holds the word it captured at the last clock edge at which the enable was low. Two select lines pick the source of every port. Each port has an output enable with its own polarity.

Top module: `trimux`

## Requirements
- R1: A port whose driver is off has its drive flag low and its output bus at all zeros. The setting a_oe_n=1, b_oe=0, c_oe_n=1 turns all three drivers off.
- R2: While a path's latch enable is low, that path is transparent: the destination output equals the source input in the same cycle, with no clock edge needed.
- R3: While a path's latch enable is high, the path outputs the source word captured at the last rising clock edge at which its enable was low, and ignores later changes to the source.
- R4: When sel1=1, port C is the source for both port A (through the C-to-A path) and port B (through the C-to-B path).
- R5: When sel1=0 and sel0=0, port B takes port A through the A-to-B path. When sel1=0 and sel0=1, port A takes port B through the B-to-A path.
- R6: Port C takes port A through the A-to-C path when sel0=0, and port B through the B-to-C path when sel0=1, whatever the value of sel1.
- R7: Port A drives when a_oe_n=0. Port B drives when b_oe=1. Port C drives when c_oe_n=0. Each enable acts alone, for every combination of the select lines.
- R8: Readback. When sel1=0 and sel0=0, port A outputs the word held in the A-to-B path. When sel1=0 and sel0=1, port B outputs the word held in the B-to-A path.
- R9: When pinv=1, bit 8 is inverted on the C-to-A and C-to-B paths only. Bits 0 to 7, the output of port C, and the A-to-B and B-to-A paths are never inverted.
- R10: After reset every path latch holds zero.
- R11: Readback on a driving port is legal only while that port's readback path is held: le_ab=1 for port A and le_ba=1 for port B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the path latches |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 9 | Port A input bus |
| b_in | input | 9 | Port B input bus |
| c_in | input | 9 | Port C input bus |
| sel0 | input | 1 | Source select, low bit |
| sel1 | input | 1 | Source select, high bit (port C feeds A and B) |
| pinv | input | 1 | Invert bit 8 on paths leaving port C |
| le_ab | input | 1 | A-to-B path latch enable (high holds) |
| le_ba | input | 1 | B-to-A path latch enable (high holds) |
| le_ac | input | 1 | A-to-C path latch enable (high holds) |
| le_ca | input | 1 | C-to-A path latch enable (high holds) |
| le_bc | input | 1 | B-to-C path latch enable (high holds) |
| le_cb | input | 1 | C-to-B path latch enable (high holds) |
| a_oe_n | input | 1 | Port A driver enable, active low |
| b_oe | input | 1 | Port B driver enable, active high |
| c_oe_n | input | 1 | Port C driver enable, active low |
| a_out | output | 9 | Port A output bus |
| a_drv | output | 1 | Port A is driving |
| b_out | output | 9 | Port B output bus |
| b_drv | output | 1 | Port B is driving |
| c_out | output | 9 | Port C output bus |
| c_drv | output | 1 | Port C is driving |

## Verification
A wrongly captured or wrongly held latch shows up at a destination port only once that path is selected, the port is driving and the latch is held. It therefore appears in the first cycle that readback or a held transfer is requested after the bad capture, and it can stay hidden for as long as the latch is left transparent. Decode faults in the select or enable logic show up in the same cycle as the stimulus, so every combination of selects and enables is compared in the cycle it is applied. A wrong parity inversion changes only bit 8, so the comparisons cover whole buses and not just the low bits.

// File: rtl/trimux_pkg.sv
package trimux_pkg;

    // One-way path indices
    localparam int P_AB = 0;
    localparam int P_BA = 1;
    localparam int P_AC = 2;
    localparam int P_CA = 3;
    localparam int P_BC = 4;
    localparam int P_CB = 5;
    localparam int NUM_PATHS = 6;

    // Source picked for a destination port
    typedef enum logic [1:0] {
        SRC_FROM_A = 2'd0,
        SRC_FROM_B = 2'd1,
        SRC_FROM_C = 2'd2,
        SRC_SELF   = 2'd3
    } src_e;

endpackage

// File: rtl/trimux_path_latch.sv
module trimux_path_latch #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] hold;
    } state_t;

    state_t st_d;
    state_t st_q;

    always_comb begin
        st_d = st_q;
        if (!le) begin
            st_d.hold = din;
        end
        dout = le ? st_q.hold : din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a held latch keeps its word across the edge
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> $stable(st_q.hold));

endmodule

// File: rtl/trimux_route.sv
module trimux_route
    import trimux_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         sel0,
    input  logic         sel1,
    input  logic         pinv,
    input  logic         a_oe_n,
    input  logic         b_oe,
    input  logic         c_oe_n,
    input  logic [W-1:0] p_ab,
    input  logic [W-1:0] p_ba,
    input  logic [W-1:0] p_ac,
    input  logic [W-1:0] p_ca,
    input  logic [W-1:0] p_bc,
    input  logic [W-1:0] p_cb,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    output logic [W-1:0] b_out,
    output logic         b_drv,
    output logic [W-1:0] c_out,
    output logic         c_drv
);

    localparam int PAR_BIT = W - 1;

    src_e         a_src;
    src_e         b_src;
    src_e         c_src;
    logic [W-1:0] flip_mask;
    logic [W-1:0] a_word;
    logic [W-1:0] b_word;
    logic [W-1:0] c_word;

    always_comb begin
        flip_mask          = '0;
        flip_mask[PAR_BIT] = pinv;

        if (sel1) begin
            a_src = SRC_FROM_C;
            b_src = SRC_FROM_C;
        end else if (sel0) begin
            a_src = SRC_FROM_B;
            b_src = SRC_SELF;
        end else begin
            a_src = SRC_SELF;
            b_src = SRC_FROM_A;
        end
        c_src = sel0 ? SRC_FROM_B : SRC_FROM_A;

        case (a_src)
            SRC_FROM_C: a_word = p_ca ^ flip_mask;
            SRC_FROM_B: a_word = p_ba;
            default:    a_word = p_ab;   // readback of A's own held word
        endcase

        case (b_src)
            SRC_FROM_C: b_word = p_cb ^ flip_mask;
            SRC_FROM_A: b_word = p_ab;
            default:    b_word = p_ba;   // readback of B's own held word
        endcase

        case (c_src)
            SRC_FROM_B: c_word = p_bc;
            default:    c_word = p_ac;
        endcase

        a_drv = ~a_oe_n;
        b_drv = b_oe;
        c_drv = ~c_oe_n;
        a_out = a_drv ? a_word : '0;
        b_out = b_drv ? b_word : '0;
        c_out = c_drv ? c_word : '0;
    end

endmodule

// File: rtl/trimux.sv
module trimux
    import trimux_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] c_in,
    input  logic         sel0,
    input  logic         sel1,
    input  logic         pinv,
    input  logic         le_ab,
    input  logic         le_ba,
    input  logic         le_ac,
    input  logic         le_ca,
    input  logic         le_bc,
    input  logic         le_cb,
    input  logic         a_oe_n,
    input  logic         b_oe,
    input  logic         c_oe_n,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    output logic [W-1:0] b_out,
    output logic         b_drv,
    output logic [W-1:0] c_out,
    output logic         c_drv
);

    localparam int PAR_BIT = W - 1;

    logic [W-1:0] path_src [NUM_PATHS];
    logic [W-1:0] path_out [NUM_PATHS];
    logic         path_le  [NUM_PATHS];

    always_comb begin
        path_src[P_AB] = a_in;  path_le[P_AB] = le_ab;
        path_src[P_BA] = b_in;  path_le[P_BA] = le_ba;
        path_src[P_AC] = a_in;  path_le[P_AC] = le_ac;
        path_src[P_CA] = c_in;  path_le[P_CA] = le_ca;
        path_src[P_BC] = b_in;  path_le[P_BC] = le_bc;
        path_src[P_CB] = c_in;  path_le[P_CB] = le_cb;
    end

    for (genvar i = 0; i < NUM_PATHS; i++) begin : g_path
        trimux_path_latch #(.W(W)) u_latch (
            .clk  (clk),
            .rst_n(rst_n),
            .le   (path_le[i]),
            .din  (path_src[i]),
            .dout (path_out[i])
        );
    end

    trimux_route #(.W(W)) u_route (
        .sel0  (sel0),
        .sel1  (sel1),
        .pinv  (pinv),
        .a_oe_n(a_oe_n),
        .b_oe  (b_oe),
        .c_oe_n(c_oe_n),
        .p_ab  (path_out[P_AB]),
        .p_ba  (path_out[P_BA]),
        .p_ac  (path_out[P_AC]),
        .p_ca  (path_out[P_CA]),
        .p_bc  (path_out[P_BC]),
        .p_cb  (path_out[P_CB]),
        .a_out (a_out),
        .a_drv (a_drv),
        .b_out (b_out),
        .b_drv (b_drv),
        .c_out (c_out),
        .c_drv (c_drv)
    );

    // R11: readback only through a held path
    p_readback_a_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drv && !sel1 && !sel0) |-> le_ab);
    p_readback_b_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (b_drv && !sel1 && sel0) |-> le_ba);

    // R6: transparent A-to-C transfer reaches port C
    p_c_from_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_drv && !sel0 && !le_ac) |-> (c_out == a_in));

    // R5: transparent B-to-A transfer reaches port A
    p_a_from_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drv && !sel1 && sel0 && !le_ba) |-> (a_out == b_in));

    // R9: parity bit from C follows pinv on port A
    p_parity_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drv && sel1 && !le_ca) |-> (a_out[PAR_BIT] == (c_in[PAR_BIT] ^ pinv)));

endmodule

// File: tb/trimux_bench.sv
module trimux_bench;

    localparam int W = 9;

    typedef struct packed {
        logic [W-1:0] a_in, b_in, c_in;
        logic sel0, sel1, pinv;
        logic le_ab, le_ba, le_ac, le_ca, le_bc, le_cb;
        logic a_oe_n, b_oe, c_oe_n;
    } stim_t;

    typedef struct {
        logic [W-1:0] a_out, b_out, c_out;
        logic a_drv, b_drv, c_drv;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    stim_t s;
    logic [W-1:0] a_out, b_out, c_out;
    logic a_drv, b_drv, c_drv;

    int total = 0;
    int bad = 0;
    exp_t sb_q[$];
    logic [W-1:0] m_ab, m_ba, m_ac, m_ca, m_bc, m_cb;

    always #2 clk = ~clk;

    trimux #(.W(W)) u_trimux (
        .clk(clk), .rst_n(rst_n),
        .a_in(s.a_in), .b_in(s.b_in), .c_in(s.c_in),
        .sel0(s.sel0), .sel1(s.sel1), .pinv(s.pinv),
        .le_ab(s.le_ab), .le_ba(s.le_ba), .le_ac(s.le_ac),
        .le_ca(s.le_ca), .le_bc(s.le_bc), .le_cb(s.le_cb),
        .a_oe_n(s.a_oe_n), .b_oe(s.b_oe), .c_oe_n(s.c_oe_n),
        .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv),
        .c_out(c_out), .c_drv(c_drv)
    );

    function automatic exp_t ref_model(stim_t v, string req);
        exp_t e;
        logic [W-1:0] pab, pba, pac, pca, pbc, pcb, aw, bw, cw;
        pab = v.le_ab ? m_ab : v.a_in;
        pba = v.le_ba ? m_ba : v.b_in;
        pac = v.le_ac ? m_ac : v.a_in;
        pca = v.le_ca ? m_ca : v.c_in;
        pbc = v.le_bc ? m_bc : v.b_in;
        pcb = v.le_cb ? m_cb : v.c_in;
        pca[W-1] = pca[W-1] ^ v.pinv;
        pcb[W-1] = pcb[W-1] ^ v.pinv;
        if (v.sel1) begin aw = pca; bw = pcb; end
        else if (v.sel0) begin aw = pba; bw = pba; end
        else begin aw = pab; bw = pab; end
        cw = v.sel0 ? pbc : pac;
        e.a_drv = !v.a_oe_n;
        e.b_drv = v.b_oe;
        e.c_drv = !v.c_oe_n;
        e.a_out = e.a_drv ? aw : '0;
        e.b_out = e.b_drv ? bw : '0;
        e.c_out = e.c_drv ? cw : '0;
        e.req = req;
        return e;
    endfunction

    // Driver: apply one vector at the falling edge and queue its expectation
    task automatic step(stim_t v, string req);
        @(negedge clk);
        // R11 guard: never request readback through a transparent path
        if ((!v.a_oe_n && !v.sel1 && !v.sel0 && !v.le_ab) ||
            (v.b_oe && !v.sel1 && v.sel0 && !v.le_ba)) begin
            total++;
            bad++;
            $display("FAIL R11 readback requested with transparent path: actual=transparent expected=held");
        end
        s = v;
        sb_q.push_back(ref_model(v, req));
        // model update at the coming rising edge
        if (!v.le_ab) m_ab = v.a_in;
        if (!v.le_ba) m_ba = v.b_in;
        if (!v.le_ac) m_ac = v.a_in;
        if (!v.le_ca) m_ca = v.c_in;
        if (!v.le_bc) m_bc = v.b_in;
        if (!v.le_cb) m_cb = v.c_in;
    endtask

    // Monitor: compare shortly after the inputs settle
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (a_out !== e.a_out || b_out !== e.b_out || c_out !== e.c_out ||
                a_drv !== e.a_drv || b_drv !== e.b_drv || c_drv !== e.c_drv) begin
                bad++;
                $display("FAIL %s actual a=%h/%b b=%h/%b c=%h/%b expected a=%h/%b b=%h/%b c=%h/%b",
                         e.req, a_out, a_drv, b_out, b_drv, c_out, c_drv,
                         e.a_out, e.a_drv, e.b_out, e.b_drv, e.c_out, e.c_drv);
            end
        end
    end

    function automatic stim_t idle();
        stim_t v;
        v = '0;
        v.le_ab = 1'b1; v.le_ba = 1'b1; v.le_ac = 1'b1;
        v.le_ca = 1'b1; v.le_bc = 1'b1; v.le_cb = 1'b1;
        v.a_oe_n = 1'b1; v.b_oe = 1'b0; v.c_oe_n = 1'b1;
        return v;
    endfunction

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        stim_t v;
        m_ab = '0; m_ba = '0; m_ac = '0; m_ca = '0; m_bc = '0; m_cb = '0;
        s = idle();
        s.a_in = 9'h1A5; s.b_in = 9'h0F3; s.c_in = 9'h13C;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all drivers off
        v = idle(); v.a_in = 9'h1A5; v.b_in = 9'h0F3; v.c_in = 9'h13C;
        step(v, "R1");
        // R10: held latches read zero after reset on every port
        v.a_oe_n = 1'b0; v.b_oe = 1'b1; v.c_oe_n = 1'b0;
        step(v, "R10");
        v.sel1 = 1'b1;
        step(v, "R10");

        // R4 and R9: C feeds A and B, transparent
        v = idle(); v.le_ca = 1'b0; v.le_cb = 1'b0; v.sel1 = 1'b1;
        v.a_oe_n = 1'b0; v.b_oe = 1'b1; v.c_in = 9'h0AA;
        step(v, "R4");
        v.pinv = 1'b1; v.c_in = 9'h155;
        step(v, "R9");
        v.c_oe_n = 1'b0; v.le_ac = 1'b0; v.a_in = 9'h123;
        step(v, "R9 port C not inverted");

        // R5: A to B and B to A, with the readback port off
        v = idle(); v.le_ab = 1'b0; v.b_oe = 1'b1; v.a_in = 9'h1C7;
        step(v, "R5");
        v = idle(); v.le_ba = 1'b0; v.sel0 = 1'b1; v.a_oe_n = 1'b0; v.b_in = 9'h138; v.pinv = 1'b1;
        step(v, "R5 no inversion");

        // R6: C source by sel0, also with sel1 high
        v = idle(); v.le_ac = 1'b0; v.le_bc = 1'b0; v.c_oe_n = 1'b0;
        v.a_in = 9'h066; v.b_in = 9'h199;
        step(v, "R6");
        v.sel0 = 1'b1;
        step(v, "R6");
        v.sel1 = 1'b1;
        step(v, "R6");

        // R2 and R3: capture then hold on A-to-C
        v = idle(); v.le_ac = 1'b0; v.c_oe_n = 1'b0; v.a_in = 9'h0D2;
        step(v, "R2");
        v.le_ac = 1'b1; v.a_in = 9'h12D;
        step(v, "R3");
        v.a_in = 9'h1FF;
        step(v, "R3");
        v.le_ac = 1'b0;
        step(v, "R2");

        // R8: readback on A
        v = idle(); v.le_ab = 1'b0; v.a_in = 9'h0B4;
        step(v, "R8 capture");
        v.le_ab = 1'b1; v.a_in = 9'h14B; v.a_oe_n = 1'b0;
        step(v, "R8 readback A");
        // R8: readback on B
        v = idle(); v.le_ba = 1'b0; v.b_in = 9'h171;
        step(v, "R8 capture");
        v.le_ba = 1'b1; v.b_in = 9'h08E; v.sel0 = 1'b1; v.b_oe = 1'b1;
        step(v, "R8 readback B");

        // R7: sweep every select and enable setting
        for (int i = 0; i < 32; i++) begin
            v = idle();
            v.le_ac = 1'b0; v.le_ca = 1'b0; v.le_bc = 1'b0; v.le_cb = 1'b0;
            v.sel0 = i[0]; v.sel1 = i[1];
            v.a_oe_n = i[2]; v.b_oe = i[3]; v.c_oe_n = i[4];
            v.pinv = i[0] ^ i[3];
            v.a_in = 9'(i * 37 + 5); v.b_in = 9'(i * 91 + 17); v.c_in = 9'(i * 53 + 300);
            step(v, "R7");
        end

        @(negedge clk);
        #2;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule